// File: doc/BRIEF.md
# I3C Controller In-Band Request Arbiter

This block decides, on behalf of an I3C controller, whether an in-band interrupt (IBI) or a controller-role request raised by a target is acknowledged. It keeps a small table with one entry per known target. Each entry holds the dynamic address that software gave the target, two acknowledge-enable bits (one per request kind), a bit that says whether an acknowledged IBI carries a mandatory data byte, a suspend bit, and a hardware-owned lock bit. Software fills the table through a simple indexed write port and reads it back through an indexed combinational read port.

The bus engine reports each incoming request as a one-cycle event carrying the 7-bit address and its kind. One cycle later the arbiter answers with ACK or NACK, says whether a data byte follows, and for suspend-enabled targets pulses a stop request and a command-queue flush. Acknowledged requests raise sticky IBI and controller-role flags. While either flag stands, every new request is refused, so software handles one request at a time. The lock bit shields the address and data-enable fields from software while the bus engine may be capturing them.

Top module: `inband_req_arbiter`

## Requirements
- R1: A write to entry `sw_wr_idx` takes a word laid out as bits [6:0] address, [7] IBI-ack-enable, [8] role-ack-enable, [9] data-enable, [10] suspend. `sw_rdata` returns entry `sw_rd_idx` in the same layout, with the lock at bit [11].
- R2: The response comes on `resp_valid` one cycle after `req_valid`. An IBI (`req_is_cr`=0) or role request (`req_is_cr`=1) from a matching entry is ACKed when that entry's enable bit for that kind is 1, and NACKed when it is 0.
- R3: A NACK raises no flag, no stop and no flush, so the transfer under way continues.
- R4: An ACKed IBI sets `ibi_flag`. An ACKed role request sets `cr_flag`. Both flags stay set until cleared.
- R5: While `ibi_flag` or `cr_flag` is 1, every request from any target is NACKed, whatever its enable bits say.
- R6: `resp_mdb` is 1 exactly when an IBI is ACKed and the entry's data-enable bit is 1.
- R7: The lock bit is 1 from the write that sets either enable bit, and for as long as either enable bit is 1. While the lock is 1 (judged before the write), writes leave the address and data-enable bits unchanged. The enable and suspend bits stay writable.
- R8: The lock drops to 0 at the second clock edge after the edge whose write cleared the last enable bit.
- R9: An ACKed IBI from an entry whose suspend bit is 1 gives a one-cycle `stop_req` and a one-cycle `flush_req`, both in the response cycle. This is intended for targets that signal pending reads with a data byte whose upper three bits are 101.
- R10: An entry whose address is 0 is unassigned and matches nothing. A request that matches no entry is NACKed and sets no flag. If several entries match, the lowest-numbered one decides.
- R11: A one-cycle `ibi_clr` or `cr_clr` clears its flag. If a new ACK and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R12: After reset, every table field, both flags and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_idx | input | 2 | Entry to write |
| sw_wdata | input | 11 | Write word (R1 layout) |
| sw_rd_idx | input | 2 | Entry to read |
| sw_rdata | output | 12 | Read word, lock at bit 11 |
| req_valid | input | 1 | Request event from bus engine |
| req_addr | input | 7 | Address of requesting target |
| req_is_cr | input | 1 | 0 = IBI, 1 = controller-role request |
| ibi_clr | input | 1 | Clear pulse for IBI flag |
| cr_clr | input | 1 | Clear pulse for role flag |
| resp_valid | output | 1 | Response strobe |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |
| resp_mdb | output | 1 | A mandatory data byte follows |
| stop_req | output | 1 | Stop the current transfer |
| flush_req | output | 1 | Flush the command queue |
| ibi_flag | output | 1 | Sticky IBI flag |
| cr_flag | output | 1 | Sticky controller-role flag |

## Verification
A wrong flag state shows up on the very next request: a stale flag turns an expected ACK into a NACK, and a lost flag lets a second request through where a NACK was due. A corrupted enable, data-enable or suspend bit appears in the response one cycle after the request, as a wrong ACK, data-byte or stop/flush value. A bad lock counter shows on the read port within two cycles of the enables being cleared, or as an address that changes while it should be frozen.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

   typedef enum logic {
      REQ_IBI  = 1'b0,
      REQ_ROLE = 1'b1
   } req_kind_e;

   // control bits sit directly above the address field
   localparam int unsigned OFS_IBI_EN = 0;
   localparam int unsigned OFS_CR_EN  = 1;
   localparam int unsigned OFS_DAT_EN = 2;
   localparam int unsigned OFS_SUSP   = 3;
   localparam int unsigned OFS_LOCK   = 4;
   localparam int unsigned CTRL_W     = 4;

endpackage

// File: rtl/ibr_dev_entry.sv
module ibr_dev_entry
   import ibr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned LOCK_DLY = 2,
   localparam int unsigned WR_W    = ADDR_W + CTRL_W,
   localparam int unsigned CNT_W   = $clog2(LOCK_DLY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WR_W-1:0]   wdata,
   output logic [ADDR_W-1:0] addr,
   output logic              ibi_en,
   output logic              cr_en,
   output logic              dat_en,
   output logic              susp,
   output logic              lock
);

   logic [CNT_W-1:0] hold_cnt;
   logic             en_nxt;

   assign en_nxt = wr_en ? (wdata[ADDR_W+OFS_IBI_EN] | wdata[ADDR_W+OFS_CR_EN])
                         : (ibi_en | cr_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr     <= '0;
         ibi_en   <= 1'b0;
         cr_en    <= 1'b0;
         dat_en   <= 1'b0;
         susp     <= 1'b0;
         lock     <= 1'b0;
         hold_cnt <= '0;
      end else begin
         if (wr_en) begin
            ibi_en <= wdata[ADDR_W+OFS_IBI_EN];
            cr_en  <= wdata[ADDR_W+OFS_CR_EN];
            susp   <= wdata[ADDR_W+OFS_SUSP];
            if (!lock) begin
               addr   <= wdata[ADDR_W-1:0];
               dat_en <= wdata[ADDR_W+OFS_DAT_EN];
            end
         end
         if (en_nxt) begin
            lock     <= 1'b1;
            hold_cnt <= CNT_W'(LOCK_DLY);
         end else if (lock) begin
            if (hold_cnt == '0) lock <= 1'b0;
            else                hold_cnt <= hold_cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/ibr_match.sv
module ibr_match #(
   parameter int unsigned N_DEV  = 4,
   parameter int unsigned ADDR_W = 7,
   localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
   input  logic [N_DEV*ADDR_W-1:0] addr_tbl,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    hit,
   output logic [IDX_W-1:0]        hit_idx
);

   logic [N_DEV-1:0] eq;

   for (genvar g = 0; g < N_DEV; g++) begin : g_cmp
      logic [ADDR_W-1:0] a;
      assign a     = addr_tbl[g*ADDR_W +: ADDR_W];
      assign eq[g] = (a != '0) && (a == req_addr);
   end

   // scan from the top so the lowest index is written last and wins
   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = N_DEV - 1; i >= 0; i--) begin
         if (eq[i]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/ibr_flags.sv
module ibr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ibi_set,
   input  logic cr_set,
   input  logic ibi_clr,
   input  logic cr_clr,
   output logic ibi_flag,
   output logic cr_flag
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ibi_flag <= 1'b0;
         cr_flag  <= 1'b0;
      end else begin
         if (ibi_set)      ibi_flag <= 1'b1;
         else if (ibi_clr) ibi_flag <= 1'b0;
         if (cr_set)       cr_flag  <= 1'b1;
         else if (cr_clr)  cr_flag  <= 1'b0;
      end
   end

endmodule

// File: rtl/inband_req_arbiter.sv
module inband_req_arbiter
   import ibr_pkg::*;
#(
   parameter int unsigned N_DEV    = 4,
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned LOCK_DLY = 2,
   localparam int unsigned IDX_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1,
   localparam int unsigned WR_W    = ADDR_W + CTRL_W,
   localparam int unsigned RD_W    = WR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr_en,
   input  logic [IDX_W-1:0]  sw_wr_idx,
   input  logic [WR_W-1:0]   sw_wdata,
   input  logic [IDX_W-1:0]  sw_rd_idx,
   output logic [RD_W-1:0]   sw_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_is_cr,
   input  logic              ibi_clr,
   input  logic              cr_clr,
   output logic              resp_valid,
   output logic              resp_ack,
   output logic              resp_mdb,
   output logic              stop_req,
   output logic              flush_req,
   output logic              ibi_flag,
   output logic              cr_flag
);

   if (N_DEV < 1) begin : g_bad_ndev
      $error("N_DEV must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (LOCK_DLY < 1) begin : g_bad_dly
      $error("LOCK_DLY must be at least 1");
   end

   logic [N_DEV*ADDR_W-1:0] addr_flat;
   logic [N_DEV-1:0]        ibi_en_v, cr_en_v, dat_en_v, susp_v, lock_v, en_v;
   logic [RD_W-1:0]         rd_word [N_DEV];

   for (genvar g = 0; g < N_DEV; g++) begin : g_dev
      logic [ADDR_W-1:0] a;
      ibr_dev_entry #(.ADDR_W(ADDR_W), .LOCK_DLY(LOCK_DLY)) u_ent (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (sw_wr_en && (sw_wr_idx == IDX_W'(g))),
         .wdata  (sw_wdata),
         .addr   (a),
         .ibi_en (ibi_en_v[g]),
         .cr_en  (cr_en_v[g]),
         .dat_en (dat_en_v[g]),
         .susp   (susp_v[g]),
         .lock   (lock_v[g])
      );
      assign addr_flat[g*ADDR_W +: ADDR_W] = a;
      assign en_v[g]    = ibi_en_v[g] | cr_en_v[g];
      assign rd_word[g] = {lock_v[g], susp_v[g], dat_en_v[g], cr_en_v[g], ibi_en_v[g], a};
   end

   always_comb begin
      sw_rdata = '0;
      for (int i = 0; i < N_DEV; i++) begin
         if (sw_rd_idx == IDX_W'(i)) sw_rdata = rd_word[i];
      end
   end

   logic             hit;
   logic [IDX_W-1:0] hit_idx;

   ibr_match #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_match (
      .addr_tbl (addr_flat),
      .req_addr (req_addr),
      .hit      (hit),
      .hit_idx  (hit_idx)
   );

   req_kind_e kind;
   logic      busy, pol, ack_d, ibi_ack, cr_ack;

   assign kind    = req_kind_e'(req_is_cr);
   assign busy    = ibi_flag | cr_flag;
   assign pol     = (kind == REQ_ROLE) ? cr_en_v[hit_idx] : ibi_en_v[hit_idx];
   assign ack_d   = req_valid & hit & ~busy & pol;
   assign ibi_ack = ack_d & (kind == REQ_IBI);
   assign cr_ack  = ack_d & (kind == REQ_ROLE);

   ibr_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ibi_set  (ibi_ack),
      .cr_set   (cr_ack),
      .ibi_clr  (ibi_clr),
      .cr_clr   (cr_clr),
      .ibi_flag (ibi_flag),
      .cr_flag  (cr_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_ack   <= 1'b0;
         resp_mdb   <= 1'b0;
         stop_req   <= 1'b0;
         flush_req  <= 1'b0;
      end else begin
         resp_valid <= req_valid;
         resp_ack   <= ack_d;
         resp_mdb   <= ibi_ack & dat_en_v[hit_idx];
         stop_req   <= ibi_ack & susp_v[hit_idx];
         flush_req  <= ibi_ack & susp_v[hit_idx];
      end
   end

endmodule

// File: rtl/inband_req_arbiter_chk.sv
module inband_req_arbiter_chk #(
   parameter int unsigned N_DEV  = 4,
   parameter int unsigned ADDR_W = 7
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_is_cr,
   input logic                    resp_valid,
   input logic                    resp_ack,
   input logic                    resp_mdb,
   input logic                    stop_req,
   input logic                    flush_req,
   input logic                    ibi_flag,
   input logic                    cr_flag,
   input logic [N_DEV-1:0]        en_v,
   input logic [N_DEV-1:0]        lock_v,
   input logic [N_DEV*ADDR_W-1:0] addr_flat
);

   p_ack_has_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      resp_ack |-> resp_valid);

   p_busy_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (ibi_flag || cr_flag)) |=> !resp_ack);

   p_ibi_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_cr) ##1 resp_ack |-> ibi_flag);

   p_cr_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_cr) ##1 resp_ack |-> cr_flag);

   p_flag_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ibi_flag) || $rose(cr_flag)) |-> $past(req_valid));

   p_mdb_only_ibi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      resp_mdb |-> (resp_ack && $past(!req_is_cr)));

   p_stop_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> (resp_ack && flush_req && $past(!req_is_cr)));

   p_flush_with_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> stop_req);

   for (genvar g = 0; g < N_DEV; g++) begin : g_ent
      p_lock_while_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
         en_v[g] |-> lock_v[g]);

      p_addr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $past(lock_v[g]) |-> $stable(addr_flat[g*ADDR_W +: ADDR_W]));

      p_lock_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(lock_v[g]) |-> (!en_v[g] && $past(!en_v[g])));
   end

endmodule

bind inband_req_arbiter inband_req_arbiter_chk #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_is_cr  (req_is_cr),
   .resp_valid (resp_valid),
   .resp_ack   (resp_ack),
   .resp_mdb   (resp_mdb),
   .stop_req   (stop_req),
   .flush_req  (flush_req),
   .ibi_flag   (ibi_flag),
   .cr_flag    (cr_flag),
   .en_v       (en_v),
   .lock_v     (lock_v),
   .addr_flat  (addr_flat)
);

// File: tb/inband_req_arbiter_tb_top.sv
module inband_req_arbiter_tb_top;

   localparam int WR_W = 11;
   localparam int RD_W = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sw_wr_en = 1'b0;
   logic [1:0]      sw_wr_idx = '0;
   logic [WR_W-1:0] sw_wdata = '0;
   logic [1:0]      sw_rd_idx = '0;
   logic [RD_W-1:0] sw_rdata;
   logic            req_valid = 1'b0;
   logic [6:0]      req_addr = '0;
   logic            req_is_cr = 1'b0;
   logic            ibi_clr = 1'b0;
   logic            cr_clr = 1'b0;
   logic            resp_valid, resp_ack, resp_mdb, stop_req, flush_req;
   logic            ibi_flag, cr_flag;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   inband_req_arbiter dut_i (
      .clk(clk), .rst_n(rst_n),
      .sw_wr_en(sw_wr_en), .sw_wr_idx(sw_wr_idx), .sw_wdata(sw_wdata),
      .sw_rd_idx(sw_rd_idx), .sw_rdata(sw_rdata),
      .req_valid(req_valid), .req_addr(req_addr), .req_is_cr(req_is_cr),
      .ibi_clr(ibi_clr), .cr_clr(cr_clr),
      .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_mdb(resp_mdb),
      .stop_req(stop_req), .flush_req(flush_req),
      .ibi_flag(ibi_flag), .cr_flag(cr_flag)
   );

   typedef struct {
      logic [2:0] exp;   // {ack, mdb, stop/flush}
      string      tag;
   } item_t;

   item_t sb_q[$];

   // monitor: one cycle after each request the response must match the queue head
   always @(negedge clk) begin
      if (rst_n) begin
         if (resp_valid) begin
            n_chk++;
            if (sb_q.size() == 0) begin
               n_bad++;
               $display("FAIL R2 unexpected response act=%b%b%b exp=none",
                        resp_ack, resp_mdb, stop_req);
            end else begin
               item_t it;
               it = sb_q.pop_front();
               if ({resp_ack, resp_mdb, stop_req} !== it.exp || flush_req !== stop_req) begin
                  n_bad++;
                  $display("FAIL %s act ack/mdb/stop/flush=%b%b%b%b exp=%b%b",
                           it.tag, resp_ack, resp_mdb, stop_req, flush_req, it.exp, it.exp[0]);
               end
            end
         end else if (resp_ack || resp_mdb || stop_req || flush_req) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 outputs without response act=%b%b%b%b exp=0000",
                     resp_ack, resp_mdb, stop_req, flush_req);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog act=%0d cycles exp=<20000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic wr(input int idx, input logic [6:0] a, input bit ie, input bit ce,
                     input bit de, input bit su);
      @(negedge clk);
      sw_wr_en  = 1'b1;
      sw_wr_idx = 2'(idx);
      sw_wdata  = {su, de, ce, ie, a};
      @(negedge clk);
      sw_wr_en  = 1'b0;
   endtask

   task automatic rd_chk(input int idx, input logic [RD_W-1:0] exp, input string tag);
      sw_rd_idx = 2'(idx);
      #1;
      n_chk++;
      if (sw_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s entry %0d act=%h exp=%h", tag, idx, sw_rdata, exp);
      end
   endtask

   task automatic req(input logic [6:0] a, input bit cr, input bit e_ack, input bit e_mdb,
                      input bit e_stop, input bit iclr, input bit cclr, input string tag);
      item_t it;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_is_cr = cr;
      ibi_clr   = iclr;
      cr_clr    = cclr;
      it.exp    = {e_ack, e_mdb, e_stop};
      it.tag    = tag;
      sb_q.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
      ibi_clr   = 1'b0;
      cr_clr    = 1'b0;
   endtask

   task automatic flags_chk(input bit ei, input bit ec, input string tag);
      n_chk++;
      if (ibi_flag !== ei || cr_flag !== ec) begin
         n_bad++;
         $display("FAIL %s flags ibi/cr act=%b%b exp=%b%b", tag, ibi_flag, cr_flag, ei, ec);
      end
   endtask

   task automatic clr(input bit i, input bit c);
      @(negedge clk);
      ibi_clr = i;
      cr_clr  = c;
      @(negedge clk);
      ibi_clr = 1'b0;
      cr_clr  = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      for (int i = 0; i < 4; i++) rd_chk(i, 12'h000, "R12 reset entry");
      flags_chk(0, 0, "R12 reset flags");

      // table: e0 0x12 IBI ack + data; e1 0x25 both acks + suspend;
      // e2 duplicate 0x25 with no acks; e3 0x40 no acks
      wr(0, 7'h12, 1, 0, 1, 0);
      wr(1, 7'h25, 1, 1, 0, 1);
      wr(2, 7'h25, 0, 0, 1, 0);
      wr(3, 7'h40, 0, 0, 0, 0);
      rd_chk(0, {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 7'h12}, "R1 R7 readback e0 locked");
      rd_chk(3, {1'b0, 4'b0000, 7'h40}, "R1 readback e3 unlocked");

      // R2 R6: IBI ack with data byte, sets IBI flag (R4)
      req(7'h12, 0, 1, 1, 0, 0, 0, "R2 R6 ibi ack with data");
      flags_chk(1, 0, "R4 ibi flag set");

      // R5: role request refused while a flag is pending
      req(7'h25, 1, 0, 0, 0, 0, 0, "R5 role nack while busy");
      flags_chk(1, 0, "R5 R3 no role flag after nack");
      clr(1, 0);
      flags_chk(0, 0, "R11 ibi flag cleared");

      // R9 R10: duplicate address, lowest entry (suspend) decides
      req(7'h25, 0, 1, 0, 1, 0, 0, "R9 R10 ibi suspend stop and flush");
      clr(1, 0);

      // R4: role request ack
      req(7'h25, 1, 1, 0, 0, 0, 0, "R2 role ack");
      flags_chk(0, 1, "R4 role flag set");
      req(7'h12, 0, 0, 0, 0, 0, 0, "R5 ibi nack while role flag");
      flags_chk(0, 1, "R5 flags unchanged");
      clr(0, 1);
      flags_chk(0, 0, "R11 role flag cleared");

      // R2 R3: disabled kinds are NACKed and raise nothing
      req(7'h40, 0, 0, 0, 0, 0, 0, "R2 ibi nack disabled entry");
      req(7'h12, 1, 0, 0, 0, 0, 0, "R2 role nack disabled kind");
      flags_chk(0, 0, "R3 no flag after nacks");

      // R10: unknown address and address 0
      req(7'h77, 0, 0, 0, 0, 0, 0, "R10 unmatched nack");
      req(7'h00, 0, 0, 0, 0, 0, 0, "R10 address zero nack");
      flags_chk(0, 0, "R10 no flag");

      // R11: set and clear together, set wins
      req(7'h12, 0, 1, 1, 0, 1, 0, "R11 ack with clear");
      flags_chk(1, 0, "R11 set wins");
      clr(1, 0);

      // R7: locked entry keeps address and data-enable
      wr(0, 7'h33, 1, 0, 0, 0);
      rd_chk(0, {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 7'h12}, "R7 write ignored while locked");
      // R8: clear enables, lock holds two edges then drops
      wr(0, 7'h33, 0, 0, 0, 0);
      rd_chk(0, {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 7'h12}, "R8 lock first cycle");
      @(negedge clk);
      rd_chk(0, {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 7'h12}, "R8 lock second cycle");
      @(negedge clk);
      rd_chk(0, {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'h12}, "R8 lock released");
      // unlocked: new address accepted
      wr(0, 7'h33, 1, 0, 0, 0);
      rd_chk(0, {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 7'h33}, "R7 write accepted after release");
      req(7'h33, 0, 1, 0, 0, 0, 0, "R6 ibi ack no data byte");
      clr(1, 0);
      req(7'h12, 0, 0, 0, 0, 0, 0, "R10 old address no longer matches");

      repeat (3) @(negedge clk);
      n_chk++;
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL R2 missing responses act=%0d exp=0", sb_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule